// File: doc/BRIEF.md
# Lockable Grouped Channel Arbiter

This block chooses which of sixteen DMA channels may run its next command. Each channel raises a request line. When no command is in flight, the arbiter picks one requester in round-robin order and raises its one-hot grant. It holds that grant until the channel pulses command-complete.

Channels 4 through 11 share one external memory device. A command from one of these group channels may carry a lock bit. When a group channel is granted a command that carries the lock bit, it becomes the lock owner. From then on, requests from the other seven group channels are left out of arbitration. Channels outside the group and the owner itself keep competing as usual.

The lock lasts across commands. It ends only when the owner completes a command whose completion reports the lock bit clear. The owner is visible at the ports so that the rest of the controller can see who holds the shared device.

Top module: `grp_lock_arbiter`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, gnt_o is all zero and lock_vld_o is 0.
- R2: gnt_o has at most one bit set. A grant rises only for a channel whose req_i bit was high in the cycle before. It rises on the clock edge that ends a cycle with no grant and at least one eligible request.
- R3: A grant stays unchanged until done_i is sampled high while it is active. It drops on that edge. A done_i pulse while gnt_o is zero has no effect.
- R4: The search for the next grant starts at the channel after the most recently granted one, wrapping from 15 to 0. After reset, channel 0 is searched first.
- R5: When a group channel (index 4 to 11) is granted while its lock_req_i bit is 1, lock_vld_o is 1 and lock_owner_o equals that index on the same edge that raises the grant.
- R6: While lock_vld_o is 1, no group channel other than lock_owner_o is granted, even if it requests.
- R7: Channels 0 to 3 and 12 to 15 are never excluded by the lock. The lock owner keeps arbitrating in round-robin order with them.
- R8: The lock is released on the edge that samples done_i high while the owner is granted and done_lock_i is 0. A completion by a non-owner channel, or an owner completion with done_lock_i at 1, leaves lock_vld_o and lock_owner_o unchanged.
- R9: A lock_req_i bit on a channel outside 4 to 11 never sets the lock.
- R10: A lock_req_i bit on a channel that does not win arbitration has no effect on the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_CH | Per-channel request |
| lock_req_i | input | NUM_CH | Lock bit of each channel's pending command |
| done_i | input | 1 | Command-complete pulse of the granted channel |
| done_lock_i | input | 1 | Lock bit of the completing command |
| gnt_o | output | NUM_CH | One-hot grant |
| lock_vld_o | output | 1 | Lock is held by a group channel |
| lock_owner_o | output | CH_W | Index of the lock owner |

## Verification
A grant appears one edge after a cycle that had no grant and an eligible request. The lock flag and owner change on that same edge. A grant drops, and a lock releases, one edge after done_i is sampled. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge. It then compares grant, lock flag and owner against the model on the next falling edge, so every result is checked in the exact cycle it is due. Directed phases cover reset, rotation, holding, lock acquisition, sibling exclusion, non-group traffic, release rules, out-of-group lock bits and losing lock bits. A long random phase follows them.

// File: rtl/gla_pkg.sv
package gla_pkg;
  function automatic logic in_grp(int unsigned idx, int unsigned lo, int unsigned hi);
    return (idx >= lo) && (idx <= hi);
  endfunction
endpackage

// File: rtl/gla_rr_pick.sv
module gla_rr_pick #(
  parameter int unsigned N = 16,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] last_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o
);
  // walk downward so the nearest channel after last_i wins
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = int'(N); k >= 1; k--) begin
      int c;
      c = int'(last_i) + k;
      if (c >= int'(N)) c = c - int'(N);
      if (req_i[c[W-1:0]]) begin
        vld_o = 1'b1;
        idx_o = c[W-1:0];
      end
    end
  end
endmodule

// File: rtl/gla_lock_ctrl.sv
module gla_lock_ctrl import gla_pkg::*; #(
  parameter int unsigned N  = 16,
  parameter int unsigned LO = 4,
  parameter int unsigned HI = 11,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         grant_fire_i,
  input  logic [W-1:0] win_idx_i,
  input  logic         win_lock_i,
  input  logic         done_fire_i,
  input  logic [W-1:0] cur_idx_i,
  input  logic         done_lock_i,
  output logic         lock_vld_o,
  output logic [W-1:0] owner_o,
  output logic [N-1:0] elig_o
);
  logic acquire, release_lk;

  assign acquire    = grant_fire_i && in_grp(int'(win_idx_i), LO, HI) && win_lock_i;
  assign release_lk = done_fire_i && lock_vld_o && (cur_idx_i == owner_o) && !done_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_vld_o <= 1'b0;
      owner_o    <= '0;
    end else if (acquire) begin
      lock_vld_o <= 1'b1;
      owner_o    <= win_idx_i;
    end else if (release_lk) begin
      lock_vld_o <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < int'(N); gi++) begin : g_elig
    if (in_grp(gi, LO, HI)) begin : g_grp
      assign elig_o[gi] = !lock_vld_o || (owner_o == W'(gi));
    end else begin : g_free
      assign elig_o[gi] = 1'b1;
    end
  end

  p_acquire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_fire_i && win_lock_i && in_grp(int'(win_idx_i), LO, HI))
      |=> (lock_vld_o && owner_o == $past(win_idx_i)));

  p_keep_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_vld_o && !(done_fire_i && cur_idx_i == owner_o && !done_lock_i))
      |=> (lock_vld_o && owner_o == $past(owner_o)));

  p_outside_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_vld_o && grant_fire_i && !in_grp(int'(win_idx_i), LO, HI)) |=> !lock_vld_o);
endmodule

// File: rtl/grp_lock_arbiter.sv
module grp_lock_arbiter import gla_pkg::*; #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned GRP_LO = 4,
  parameter int unsigned GRP_HI = 11,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] lock_req_i,
  input  logic              done_i,
  input  logic              done_lock_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              lock_vld_o,
  output logic [CH_W-1:0]   lock_owner_o
);
  logic              gnt_vld;
  logic [CH_W-1:0]   gnt_idx;   // doubles as round-robin pointer
  logic [NUM_CH-1:0] elig, req_m, grp_mask, sib_mask;
  logic              pick_vld, grant_fire, done_fire;
  logic [CH_W-1:0]   pick_idx;

  assign req_m      = req_i & elig;
  assign grant_fire = !gnt_vld && pick_vld;
  assign done_fire  = gnt_vld && done_i;

  gla_rr_pick #(.N(NUM_CH)) u_pick (
    .req_i  (req_m),
    .last_i (gnt_idx),
    .vld_o  (pick_vld),
    .idx_o  (pick_idx)
  );

  gla_lock_ctrl #(.N(NUM_CH), .LO(GRP_LO), .HI(GRP_HI)) u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .grant_fire_i (grant_fire),
    .win_idx_i    (pick_idx),
    .win_lock_i   (lock_req_i[pick_idx]),
    .done_fire_i  (done_fire),
    .cur_idx_i    (gnt_idx),
    .done_lock_i  (done_lock_i),
    .lock_vld_o   (lock_vld_o),
    .owner_o      (lock_owner_o),
    .elig_o       (elig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_vld <= 1'b0;
      gnt_idx <= CH_W'(NUM_CH - 1);
    end else if (gnt_vld) begin
      if (done_i) gnt_vld <= 1'b0;
    end else if (pick_vld) begin
      gnt_vld <= 1'b1;
      gnt_idx <= pick_idx;
    end
  end

  for (genvar gi = 0; gi < int'(NUM_CH); gi++) begin : g_out
    assign gnt_o[gi]    = gnt_vld && (gnt_idx == CH_W'(gi));
    assign grp_mask[gi] = in_grp(gi, GRP_LO, GRP_HI);
    assign sib_mask[gi] = grp_mask[gi] && (lock_owner_o != CH_W'(gi));
  end

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o));

  p_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |=> ((gnt_o & ~$past(req_i)) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && !done_i) |=> $stable(gnt_o));

  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && done_i) |=> (gnt_o == '0));

  p_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_vld_o && gnt_o == '0) |=> ((gnt_o & $past(sib_mask)) == '0));
endmodule

// File: tb/grp_lock_arbiter_test.sv
module grp_lock_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0, lock_req_i = '0;
  logic          done_i = 1'b0, done_lock_i = 1'b0;
  logic [N-1:0]  gnt_o;
  logic          lock_vld_o;
  logic [3:0]    lock_owner_o;

  grp_lock_arbiter uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .lock_req_i(lock_req_i),
    .done_i(done_i), .done_lock_i(done_lock_i), .gnt_o(gnt_o),
    .lock_vld_o(lock_vld_o), .lock_owner_o(lock_owner_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  string tag = "R1";
  int hold = 1, hcnt = 0;
  bit dl_follow = 0, dl_val = 0;

  // behavioural reference
  int ref_gnt = -1, ref_last = N-1, ref_owner = 0;
  bit ref_lock = 0;

  function automatic bit grp(int c);
    return c >= 4 && c <= 11;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_gnt = -1; ref_last = N-1; ref_lock = 0; ref_owner = 0;
    end else if (ref_gnt >= 0) begin
      if (done_i) begin
        if (ref_lock && ref_owner == ref_gnt && !done_lock_i) ref_lock = 0;
        ref_gnt = -1;
      end
    end else begin
      for (int k = 1; k <= N; k++) begin
        int c;
        c = (ref_last + k) % N;
        if (ref_gnt < 0 && req_i[c] && !(ref_lock && grp(c) && c != ref_owner)) begin
          ref_gnt = c; ref_last = c;
          if (grp(c) && lock_req_i[c]) begin ref_lock = 1; ref_owner = c; end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("gnt", int'(gnt_o), ref_gnt >= 0 ? (1 << ref_gnt) : 0);
    chk("lock", int'(lock_vld_o), int'(ref_lock));
    if (ref_lock) chk("owner", int'(lock_owner_o), ref_owner);
    if (gnt_o != '0) begin
      hcnt++;
      done_i = (hcnt >= hold);
      if (done_i) hcnt = 0;
    end else begin
      done_i = 0; hcnt = 0;
    end
    done_lock_i = dl_follow ? |(gnt_o & lock_req_i) : dl_val;
  endtask

  task automatic run(string t, int n);
    tag = t;
    for (int i = 0; i < n; i++) step();
  endtask

  localparam logic [N-1:0] GRP = 16'h0FF0;

  initial begin
    // R1: reset state
    run("R1", 3);
    rst_ni = 1'b1;
    run("R1", 1);
    // R4: rotation over all channels
    req_i = '1; hold = 1;
    run("R4", 40);
    // R3: long hold, then idle done pulses
    req_i = 16'h0008; hold = 5;
    run("R3", 16);
    req_i = '0;
    run("R3", 4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("gnt idle", int'(gnt_o), 0);
      done_i = 1'b1;
    end
    run("R3", 2);
    // R5: acquire lock on channel 6
    hold = 2; dl_val = 1;
    req_i = 16'h0040; lock_req_i = 16'h0040;
    run("R5", 8);
    // R6: siblings requesting are excluded
    req_i = GRP;
    run("R6", 30);
    // R7: outside channels and owner share rotation
    req_i = GRP | 16'h2004;
    run("R7", 30);
    // R8: owner completes unlocked command
    lock_req_i = '0; dl_val = 0;
    run("R8", 30);
    // R8: non-owner completion leaves lock held
    req_i = 16'h0604; lock_req_i = 16'h0200; dl_follow = 1;
    run("R8", 30);
    lock_req_i = '0; req_i = GRP;
    run("R8", 20);
    // R9: lock bit outside group
    req_i = 16'h4002; lock_req_i = 16'h4002;
    run("R9", 20);
    // R10: lock bit on a losing channel
    req_i = 16'h0030; lock_req_i = 16'h0020; dl_follow = 0; dl_val = 1;
    run("R10", 6);
    lock_req_i = '0; dl_val = 0;
    run("R10", 12);
    // R2: random traffic
    dl_follow = 0;
    for (int i = 0; i < 3000; i++) begin
      if (i % 7 == 0) begin
        req_i = N'($urandom); lock_req_i = N'($urandom) & N'($urandom);
        hold = 1 + int'($urandom_range(3));
        dl_val = $urandom_range(1) == 1;
      end
      run("R2", 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule